// File: doc/BRIEF.md
# CAN Acceptance Mask Filter Bank

This block decides, for one received CAN identifier, which receive message buffers and which receive-FIFO filter-table entries accept it. It holds a set of acceptance masks written through a small write-only register port: one shared mask, two dedicated masks (tied to buffers 14 and 15 and to FIFO elements 6 and 7), and one individual mask per buffer. For every candidate it picks a mask by index and by mode, compares the masked received word against that candidate's programmed filter word, and reports a hit vector together with the lowest-index hit.

Two mode inputs steer mask selection. With individual masking off, most candidates share the common mask and the four special positions use the dedicated masks. With it on, the shared and dedicated masks are ignored and every candidate uses its own individual mask. A FIFO-enable input decides whether the filter-table entries can hit at all. Mask writes are only accepted while the freeze input is high. The filter words, the receive-enable flags and the received fields come in on plain ports. The result appears one cycle after a compare strobe.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every mask (shared, both dedicated, all individual) is all ones, so every compared bit has to match exactly.
- R2: A mask bit of 0 makes the matching filter bit a don't-care. A mask bit of 1 requires the received bit to equal the filter bit.
- R3: With individual masking off, buffer 14 uses the first dedicated mask, buffer 15 uses the second dedicated mask, and every other buffer uses the shared mask.
- R4: With individual masking off, FIFO element 6 uses the first dedicated mask, element 7 uses the second dedicated mask, and every other element uses the shared mask.
- R5: The received word is {RTR at bit 31, IDE at bit 30, 0 at bit 29, identifier in bits 28..0}. A standard identifier sits in bits 28..18. Buffer compares use bits 28..0 only. FIFO compares use bits 31, 30 and 28..0. Bit 29 is never compared.
- R6: With individual masking on, buffer i and FIFO element i both use individual mask i. The shared and dedicated masks then have no effect.
- R7: A mask write takes effect only when freeze is high on that clock edge. Writes at any other time, and writes to unmapped addresses, change nothing.
- R8: A buffer can hit only while its receive-enable bit is 1. A FIFO element can hit only while the FIFO-enable input is 1.
- R9: One cycle after the cycle with the compare strobe high, resValid is 1 for exactly one cycle. The hit vectors, each group's valid flag and the lowest set index of each group appear in that same cycle. With no strobe, resValid is 0.
- R10: Register addresses are: 0 for the shared mask, 1 for the first dedicated mask, 2 for the second dedicated mask, and 16+i for individual mask i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Enables mask writes when high |
| wrEn | input | 1 | Mask write request |
| wrAddr | input | 6 | Mask register address |
| wrData | input | 32 | Mask write data |
| indivMode | input | 1 | 1 selects per-buffer individual masks |
| fifoEn | input | 1 | 1 lets FIFO filter elements hit |
| mbRxEn | input | 16 | Per-buffer receive enable |
| mbFilter | input | 512 | Buffer filter words, buffer i at bits [32i+31:32i] |
| fifoFilter | input | 256 | FIFO filter words, element k at bits [32k+31:32k] |
| cmpStrobe | input | 1 | Starts a compare of the received fields |
| rxId | input | 29 | Received identifier |
| rxIde | input | 1 | Received IDE bit |
| rxRtr | input | 1 | Received RTR bit |
| resValid | output | 1 | Result valid pulse |
| mbHit | output | 16 | Buffer hit vector |
| mbHitValid | output | 1 | At least one buffer hit |
| mbHitIdx | output | 4 | Lowest hitting buffer index |
| fifoHit | output | 8 | FIFO element hit vector |
| fifoHitValid | output | 1 | At least one FIFO element hit |
| fifoHitIdx | output | 3 | Lowest hitting FIFO element index |

## Verification
The hardest case to reach is one where the shared, dedicated and individual masks all hold different values, so that choosing the wrong mask for one index changes exactly one hit bit. Random filter words are too unlikely to land there. The stimulus therefore sets every filter word equal to the received word with a single bit flipped, and clears one mask at a time. Each directed step then expects a hit pattern that singles out positions 14/15 or 6/7, or the one buffer whose individual mask is cleared. A frozen-versus-unfrozen write to the same mask is followed by the same compare, so an ignored write shows up in the hit vector. Random rounds then mix sparse bit flips, random masks written with freeze high or low, and random modes.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;
  localparam int MaskW   = 32;
  localparam int SelW    = 8;
  // word layout: RTR at 31, IDE at 30, bit 29 unused, identifier in 28..0
  localparam logic [MaskW-1:0] MbCmpBits   = 32'h1FFF_FFFF;
  localparam logic [MaskW-1:0] FifoCmpBits = 32'hDFFF_FFFF;

  typedef struct packed {
    logic            wrShared;
    logic            wrDedA;
    logic            wrDedB;
    logic            wrIndiv;
    logic [SelW-1:0] indivSel;
    logic            capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/can_accept_ctrl.sv
module can_accept_ctrl
  import can_accept_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_MB     = 16,
  parameter int INDIV_BASE = 16
) (
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              cmpStrobe,
  output ctrlStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] AddrShared = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AddrDedA   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AddrDedB   = ADDR_W'(2);
  localparam int                IndivTop   = INDIV_BASE + NUM_MB;

  logic wrOk;
  logic inIndivRange;
  int   addrInt;

  always_comb begin
    wrOk         = wrEn && freeze;
    addrInt      = int'(wrAddr);
    inIndivRange = (addrInt >= INDIV_BASE) && (addrInt < IndivTop);
    strb.wrShared = wrOk && (wrAddr == AddrShared);
    strb.wrDedA   = wrOk && (wrAddr == AddrDedA);
    strb.wrDedB   = wrOk && (wrAddr == AddrDedB);
    strb.wrIndiv  = wrOk && inIndivRange;
    strb.indivSel = inIndivRange ? SelW'(addrInt - INDIV_BASE) : '0;
    strb.capture  = cmpStrobe;
  end
endmodule

// File: rtl/can_accept_prio.sv
module can_accept_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/can_accept_dp.sv
module can_accept_dp
  import can_accept_pkg::*;
#(
  parameter int NUM_MB   = 16,
  parameter int FIFO_N   = 8,
  parameter int DED_MB_A = 14,
  parameter int DED_MB_B = 15,
  parameter int DED_FF_A = 6,
  parameter int DED_FF_B = 7,
  parameter int MB_IW    = 4,
  parameter int FF_IW    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [MaskW-1:0]        wrData,
  input  logic                    indivMode,
  input  logic                    fifoEn,
  input  logic [NUM_MB-1:0]       mbRxEn,
  input  logic [NUM_MB*MaskW-1:0] mbFilter,
  input  logic [FIFO_N*MaskW-1:0] fifoFilter,
  input  logic [28:0]             rxId,
  input  logic                    rxIde,
  input  logic                    rxRtr,
  output logic                    resValid,
  output logic [NUM_MB-1:0]       mbHit,
  output logic                    mbHitValid,
  output logic [MB_IW-1:0]        mbHitIdx,
  output logic [FIFO_N-1:0]       fifoHit,
  output logic                    fifoHitValid,
  output logic [FF_IW-1:0]        fifoHitIdx
);
  logic [MaskW-1:0] sharedMask;
  logic [MaskW-1:0] dedMaskA;
  logic [MaskW-1:0] dedMaskB;
  logic [MaskW-1:0] indivMask [NUM_MB];

  // mask storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sharedMask <= '1;
      dedMaskA   <= '1;
      dedMaskB   <= '1;
      for (int i = 0; i < NUM_MB; i++) indivMask[i] <= '1;
    end else begin
      if (strb.wrShared) sharedMask <= wrData;
      if (strb.wrDedA)   dedMaskA   <= wrData;
      if (strb.wrDedB)   dedMaskB   <= wrData;
      for (int i = 0; i < NUM_MB; i++) begin
        if (strb.wrIndiv && (int'(strb.indivSel) == i)) indivMask[i] <= wrData;
      end
    end
  end

  logic [MaskW-1:0]  rxWord;
  logic [NUM_MB-1:0] mbHitNext;
  logic [FIFO_N-1:0] fifoHitNext;

  assign rxWord = {rxRtr, rxIde, 1'b0, rxId};

  // per-buffer mask selection and compare
  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic [MaskW-1:0] selMask;
    logic [MaskW-1:0] diff;
    always_comb begin
      if (indivMode)          selMask = indivMask[g];
      else if (g == DED_MB_A) selMask = dedMaskA;
      else if (g == DED_MB_B) selMask = dedMaskB;
      else                    selMask = sharedMask;
      diff = (rxWord ^ mbFilter[g*MaskW +: MaskW]) & selMask & MbCmpBits;
      mbHitNext[g] = mbRxEn[g] && (diff == '0);
    end
  end

  // per-element mask selection and compare for the FIFO filter table
  for (genvar k = 0; k < FIFO_N; k++) begin : g_ff
    logic [MaskW-1:0] selMask;
    logic [MaskW-1:0] diff;
    always_comb begin
      if (indivMode)          selMask = (k < NUM_MB) ? indivMask[k] : '1;
      else if (k == DED_FF_A) selMask = dedMaskA;
      else if (k == DED_FF_B) selMask = dedMaskB;
      else                    selMask = sharedMask;
      diff = (rxWord ^ fifoFilter[k*MaskW +: MaskW]) & selMask & FifoCmpBits;
      fifoHitNext[k] = fifoEn && (diff == '0);
    end
  end

  logic             mbAnyNext;
  logic [MB_IW-1:0] mbIdxNext;
  logic             ffAnyNext;
  logic [FF_IW-1:0] ffIdxNext;

  can_accept_prio #(.N(NUM_MB), .IW(MB_IW)) u_mbPrio (
    .vec(mbHitNext), .any(mbAnyNext), .idx(mbIdxNext)
  );
  can_accept_prio #(.N(FIFO_N), .IW(FF_IW)) u_ffPrio (
    .vec(fifoHitNext), .any(ffAnyNext), .idx(ffIdxNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      mbHit        <= '0;
      mbHitValid   <= 1'b0;
      mbHitIdx     <= '0;
      fifoHit      <= '0;
      fifoHitValid <= 1'b0;
      fifoHitIdx   <= '0;
    end else begin
      resValid <= strb.capture;
      if (strb.capture) begin
        mbHit        <= mbHitNext;
        mbHitValid   <= mbAnyNext;
        mbHitIdx     <= mbIdxNext;
        fifoHit      <= fifoHitNext;
        fifoHitValid <= ffAnyNext;
        fifoHitIdx   <= ffIdxNext;
      end
    end
  end

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> resValid);
  // R9
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> !resValid);
  // R8
  rx_enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> ((mbHit & ~$past(mbRxEn)) == '0));
  // R8
  fifo_enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !fifoEn) |=> (fifoHit == '0));
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_accept_pkg::*;
#(
  parameter int NUM_MB     = 16,
  parameter int FIFO_N     = 8,
  parameter int ADDR_W     = 6,
  parameter int INDIV_BASE = 16,
  parameter int DED_MB_A   = 14,
  parameter int DED_MB_B   = 15,
  parameter int DED_FF_A   = 6,
  parameter int DED_FF_B   = 7,
  localparam int MB_IW     = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int FF_IW     = (FIFO_N > 1) ? $clog2(FIFO_N) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    freeze,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [31:0]             wrData,
  input  logic                    indivMode,
  input  logic                    fifoEn,
  input  logic [NUM_MB-1:0]       mbRxEn,
  input  logic [NUM_MB*32-1:0]    mbFilter,
  input  logic [FIFO_N*32-1:0]    fifoFilter,
  input  logic                    cmpStrobe,
  input  logic [28:0]             rxId,
  input  logic                    rxIde,
  input  logic                    rxRtr,
  output logic                    resValid,
  output logic [NUM_MB-1:0]       mbHit,
  output logic                    mbHitValid,
  output logic [MB_IW-1:0]        mbHitIdx,
  output logic [FIFO_N-1:0]       fifoHit,
  output logic                    fifoHitValid,
  output logic [FF_IW-1:0]        fifoHitIdx
);
  ctrlStrobes_t strb;

  can_accept_ctrl #(.ADDR_W(ADDR_W), .NUM_MB(NUM_MB), .INDIV_BASE(INDIV_BASE)) u_ctrl (
    .freeze(freeze), .wrEn(wrEn), .wrAddr(wrAddr), .cmpStrobe(cmpStrobe), .strb(strb)
  );

  can_accept_dp #(
    .NUM_MB(NUM_MB), .FIFO_N(FIFO_N),
    .DED_MB_A(DED_MB_A), .DED_MB_B(DED_MB_B),
    .DED_FF_A(DED_FF_A), .DED_FF_B(DED_FF_B),
    .MB_IW(MB_IW), .FF_IW(FF_IW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .indivMode(indivMode), .fifoEn(fifoEn), .mbRxEn(mbRxEn),
    .mbFilter(mbFilter), .fifoFilter(fifoFilter),
    .rxId(rxId), .rxIde(rxIde), .rxRtr(rxRtr),
    .resValid(resValid), .mbHit(mbHit), .mbHitValid(mbHitValid), .mbHitIdx(mbHitIdx),
    .fifoHit(fifoHit), .fifoHitValid(fifoHitValid), .fifoHitIdx(fifoHitIdx)
  );

  // R7
  shared_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freeze |=> $stable(u_dp.sharedMask));
  // R7
  dedicated_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freeze |=> ($stable(u_dp.dedMaskA) && $stable(u_dp.dedMaskB)));
  // R9
  mb_index_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && mbHitValid) |-> (mbHit[mbHitIdx] &&
      ((mbHit & ((NUM_MB'(1) << mbHitIdx) - NUM_MB'(1))) == '0)));
  // R9
  fifo_index_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && fifoHitValid) |-> (fifoHit[fifoHitIdx] &&
      ((fifoHit & ((FIFO_N'(1) << fifoHitIdx) - FIFO_N'(1))) == '0)));
endmodule

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;
  localparam int NMB = 16;
  localparam int NFF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freeze = 1'b0, wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic indivMode = 1'b0, fifoEn = 1'b0;
  logic [NMB-1:0] mbRxEn = '0;
  logic [NMB*32-1:0] mbFilter = '0;
  logic [NFF*32-1:0] fifoFilter = '0;
  logic cmpStrobe = 1'b0;
  logic [28:0] rxId = '0;
  logic rxIde = 1'b0, rxRtr = 1'b0;
  logic resValid, mbHitValid, fifoHitValid;
  logic [NMB-1:0] mbHit;
  logic [3:0] mbHitIdx;
  logic [NFF-1:0] fifoHit;
  logic [2:0] fifoHitIdx;

  can_accept_filter dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mShared = '1, mDedA = '1, mDedB = '1;
  logic [31:0] mInd [NMB];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rxw();
    return {rxRtr, rxIde, 1'b0, rxId};
  endfunction

  function automatic logic [31:0] mbMask(input int i);
    if (indivMode) return mInd[i];
    if (i == 14) return mDedA;
    if (i == 15) return mDedB;
    return mShared;
  endfunction

  function automatic logic [31:0] ffMask(input int k);
    if (indivMode) return mInd[k];
    if (k == 6) return mDedA;
    if (k == 7) return mDedB;
    return mShared;
  endfunction

  function automatic logic [NMB-1:0] expMb();
    logic [NMB-1:0] v;
    for (int i = 0; i < NMB; i++)
      v[i] = mbRxEn[i] && (((rxw() ^ mbFilter[i*32 +: 32]) & mbMask(i) & 32'h1FFF_FFFF) == 0);
    return v;
  endfunction

  function automatic logic [NFF-1:0] expFf();
    logic [NFF-1:0] v;
    for (int k = 0; k < NFF; k++)
      v[k] = fifoEn && (((rxw() ^ fifoFilter[k*32 +: 32]) & ffMask(k) & 32'hDFFF_FFFF) == 0);
    return v;
  endfunction

  function automatic int lowest(input logic [NMB-1:0] v);
    for (int i = 0; i < NMB; i++) if (v[i]) return i;
    return 0;
  endfunction

  // R10 address map, R7 freeze gating mirrored in the model
  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    if (freeze) begin
      if (a == 0) mShared = d;
      else if (a == 1) mDedA = d;
      else if (a == 2) mDedB = d;
      else if (a >= 16 && a < 32) mInd[a-16] = d;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAllFilters(input logic [31:0] f);
    for (int i = 0; i < NMB; i++) mbFilter[i*32 +: 32] = f;
    for (int k = 0; k < NFF; k++) fifoFilter[k*32 +: 32] = f;
  endtask

  task automatic compare(input string req);
    logic [NMB-1:0] em; logic [NFF-1:0] ef;
    @(negedge clk);
    em = expMb(); ef = expFf();
    cmpStrobe = 1'b1;
    @(negedge clk);
    cmpStrobe = 1'b0;
    chk({req, " R9 valid"}, 64'(resValid), 64'(1));
    chk({req, " mbHit"}, 64'(mbHit), 64'(em));
    chk({req, " fifoHit"}, 64'(fifoHit), 64'(ef));
    chk({req, " R9 mbValid"}, 64'(mbHitValid), 64'(em != 0));
    chk({req, " R9 ffValid"}, 64'(fifoHitValid), 64'(ef != 0));
    if (em != 0) chk({req, " R9 mbIdx"}, 64'(mbHitIdx), 64'(lowest(em)));
    if (ef != 0) chk({req, " R9 ffIdx"}, 64'(fifoHitIdx), 64'(lowest(NMB'(ef))));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finishRun();
  end

  logic [31:0] base;

  initial begin
    for (int i = 0; i < NMB; i++) mInd[i] = '1;
    process::self().srandom(32'd12345);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset resValid", 64'(resValid), 64'(0));
    chk("R9 reset mbHit", 64'(mbHit), 64'(0));

    // R1: all masks ones after reset
    rxId = 29'h0ABC_1234; rxIde = 1'b1; rxRtr = 1'b0;
    base = rxw();
    mbRxEn = '1; fifoEn = 1'b1;
    setAllFilters(base);
    compare("R1 exact");
    setAllFilters(base ^ 32'h0004_0000);
    compare("R1 one-bit diff");
    chk("R1 none hit", 64'(mbHit), 64'(0));
    @(negedge clk);
    chk("R9 pulse ends", 64'(resValid), 64'(0));

    // R7: write without freeze ignored
    freeze = 1'b0;
    writeReg(6'd0, 32'h0);
    compare("R7 unfrozen write");
    chk("R7 still none", 64'(mbHit), 64'(0));

    // R3/R4/R2: shared mask clears the differing bit
    freeze = 1'b1;
    writeReg(6'd0, 32'hFFFB_FFFF);
    compare("R3 R4 shared cleared");
    chk("R3 mb pattern", 64'(mbHit), 64'(16'h3FFF));
    chk("R4 fifo pattern", 64'(fifoHit), 64'(8'h3F));
    writeReg(6'd1, 32'h0);
    compare("R3 R4 dedA cleared");
    chk("R3 mb14 on", 64'(mbHit), 64'(16'h7FFF));
    chk("R4 elem6 on", 64'(fifoHit), 64'(8'h7F));
    writeReg(6'd5, 32'h0); // unmapped, R7
    writeReg(6'd2, 32'h0);
    compare("R3 R4 dedB cleared");

    // R5: RTR/IDE excluded from buffers, included for FIFO
    writeReg(6'd0, '1); writeReg(6'd1, '1); writeReg(6'd2, '1);
    setAllFilters(base ^ 32'h8000_0000);
    compare("R5 rtr flip");
    chk("R5 mb ignore rtr", 64'(mbHit), 64'(16'hFFFF));
    chk("R5 fifo checks rtr", 64'(fifoHit), 64'(0));
    setAllFilters(base ^ 32'h2000_0000);
    compare("R5 bit29 ignored");

    // R6: individual masks only
    setAllFilters(base ^ 32'h0004_0000);
    writeReg(6'd0, 32'h0); writeReg(6'd1, 32'h0); writeReg(6'd2, 32'h0);
    writeReg(6'd19, 32'h0);
    indivMode = 1'b1;
    compare("R6 indiv");
    chk("R6 only buffer 3", 64'(mbHit), 64'(16'h0008));
    chk("R6 only elem 3", 64'(fifoHit), 64'(8'h08));
    indivMode = 1'b0;

    // R8: receive enables and FIFO enable
    mbRxEn = 16'hA0A0; fifoEn = 1'b0;
    compare("R8 gated");
    chk("R8 fifo off", 64'(fifoHit), 64'(0));
    mbRxEn = '1; fifoEn = 1'b1;

    // random rounds
    for (int n = 0; n < 400; n++) begin
      logic [31:0] fl;
      if ($urandom_range(0, 3) == 0) begin
        freeze = $urandom_range(0, 1) == 1;
        writeReg(6'($urandom_range(0, 40)), $urandom | $urandom);
      end
      indivMode = $urandom_range(0, 2) == 0;
      fifoEn = $urandom_range(0, 3) != 0;
      mbRxEn = NMB'($urandom | $urandom);
      rxId = 29'($urandom); rxIde = 1'($urandom); rxRtr = 1'($urandom);
      for (int i = 0; i < NMB; i++) begin
        fl = $urandom & $urandom & $urandom & $urandom & $urandom;
        mbFilter[i*32 +: 32] = rxw() ^ fl;
      end
      for (int k = 0; k < NFF; k++) begin
        fl = $urandom & $urandom & $urandom & $urandom & $urandom;
        fifoFilter[k*32 +: 32] = rxw() ^ fl;
      end
      compare("R2 random");
    end
    finishRun();
  end
endmodule